// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block is a 32-pin general-purpose I/O bank controlled through a small APB-style register port. Each pin has one output-value bit and one direction bit. Each 32-bit logical register is stored as two 16-bit halves at separate word offsets: one for pins 0 to 15 and one for pins 16 to 31. The block drives an output-enable vector and an output-value vector toward the pads. It takes a 32-bit pin input vector back from them.

Every writable half is updated with a masked write. The upper 16 bits of the write word select which of the lower 16 bits are changed. Software can therefore set or clear any group of pins in one write, without first reading the register back. A read-only word returns the synchronized pin levels. Another read-only word returns a nonzero version code. Software can use that code to recognise the split-half, masked layout.

Top module: `gpio_mask_bank`

## Requirements
- R1: While reset is applied, and afterwards until the first write, every output-value and direction bit is 0, so `gpio_oe` and `gpio_out` are all zero.
- R2: A write to offset 0x00 changes bit k of pins 0–15 (k = 0..15) to write-data bit k only when write-data bit k+16 is 1. Every other bit keeps its value.
- R3: Offset 0x04 holds the output values of pins 16–31, with pin n at bit n−16. It uses the same masked-write rule as R2.
- R4: Offsets 0x08 (pins 0–15) and 0x0C (pins 16–31, pin n at bit n−16) hold the direction bits and use the masked-write rule. A direction bit of 1 drives `gpio_oe` high for that pin (output), and 0 makes the pin an input.
- R5: `gpio_out[n]` always equals the stored output-value bit of pin n, for pins 0–31.
- R6: A read of offset 0x00, 0x04, 0x08 or 0x0C returns the stored 16 bits in `prdata[15:0]` and zeros in `prdata[31:16]`.
- R7: A read of offset 0x70 returns the level of pin n in bit n, taken from `gpio_in` through a synchronizer of SYNC_STAGES flip-flops.
- R8: A read of offset 0x78 returns the parameter VERSION_ID, which is nonzero. Writes to 0x70 and 0x78 change no state.
- R9: A read of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x70 and 0x78 returns zero. A write to any such offset changes no state.
- R10: A register is written only on a clock edge where `psel`, `penable` and `pwrite` are all 1. Any other combination leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | 32 | Write word: bits 31:16 enable, bits 15:0 data |
| prdata | output | 32 | Read word, valid during the access phase |
| gpio_in | input | 32 | Pin levels from the pads |
| gpio_oe | output | 32 | Per-pin output enable (1 = output) |
| gpio_out | output | 32 | Per-pin output value |

## Verification
The bench builds the bank with ADDR_W = 8 and SYNC_STAGES = 2, and with VERSION_ID overridden to 32'h0002_0517. The override shows that the version word comes from the parameter and not from a fixed constant. With an 8-bit address, every mapped offset and several unmapped offsets (0x10, 0x40) can be reached. Two synchronizer stages allow each pin-level read to be timed to a known settling delay. Partial enable masks on both halves of both registers show that the low-half and high-half mappings each keep the bits whose enable is 0.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int PIN_COUNT = 32;
  localparam int HALF_W    = PIN_COUNT / 2;
  localparam int WORD_W    = 32;
  localparam int NUM_HALF  = 4;   // data lo, data hi, dir lo, dir hi

  // word offsets; half i sits at byte offset 4*i
  localparam logic [7:0] OFS_LEVEL = 8'h70;
  localparam logic [7:0] OFS_VER   = 8'h78;

  typedef enum logic [1:0] {
    HALF_DATA_LO = 2'd0,
    HALF_DATA_HI = 2'd1,
    HALF_DIR_LO  = 2'd2,
    HALF_DIR_HI  = 2'd3
  } half_idx_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_sync = stg_q[1];
endmodule

// File: rtl/gpio_level_sync.sv
module gpio_level_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_mask_half.sv
module gpio_mask_half #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2*W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] bit_en;
  logic [W-1:0] q_nxt;

  // next state: take new bits where enabled, keep the rest
  always_comb begin
    bit_en = wdata[2*W-1:W];
    q_nxt  = (q & ~bit_en) | (wdata[W-1:0] & bit_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= q_nxt;
  end
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank #(
  parameter int          ADDR_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] VERSION_ID  = 32'h0001_0A01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [31:0]       gpio_in,
  output logic [31:0]       gpio_oe,
  output logic [31:0]       gpio_out
);
  import gpio_mask_pkg::*;

  logic              rst_n_i;
  logic              wr_acc;
  logic [HALF_W-1:0] half_q [NUM_HALF];
  logic [PIN_COUNT-1:0] level_q;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  gpio_level_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_lvl (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     (gpio_in),
    .q     (level_q)
  );

  assign wr_acc = psel & penable & pwrite;

  for (genvar i = 0; i < NUM_HALF; i++) begin : g_half
    logic hit;
    assign hit = (paddr == ADDR_W'(4 * i));

    gpio_mask_half #(.W(HALF_W)) u_half (
      .clk   (clk),
      .rst_n (rst_n_i),
      .wr_en (wr_acc & hit),
      .wdata (pwdata),
      .q     (half_q[i])
    );
  end

  assign gpio_out = {half_q[HALF_DATA_HI], half_q[HALF_DATA_LO]};
  assign gpio_oe  = {half_q[HALF_DIR_HI],  half_q[HALF_DIR_LO]};

  always_comb begin
    prdata = '0;
    for (int i = 0; i < NUM_HALF; i++) begin
      if (paddr == ADDR_W'(4 * i)) prdata = {{(WORD_W-HALF_W){1'b0}}, half_q[i]};
    end
    if (paddr == ADDR_W'(OFS_LEVEL)) prdata = level_q;
    if (paddr == ADDR_W'(OFS_VER))   prdata = VERSION_ID;
  end
endmodule

// File: rtl/gpio_mask_bank_chk.sv
module gpio_mask_bank_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [31:0]       prdata,
  input logic [31:0]       gpio_oe,
  input logic [31:0]       gpio_out
);
  logic rd_acc, wr_acc, half_addr, mapped;
  assign rd_acc    = psel && penable && !pwrite;
  assign wr_acc    = psel && penable && pwrite;
  assign half_addr = (paddr == ADDR_W'(8'h00)) || (paddr == ADDR_W'(8'h04)) ||
                     (paddr == ADDR_W'(8'h08)) || (paddr == ADDR_W'(8'h0C));
  assign mapped    = half_addr || (paddr == ADDR_W'(8'h70)) || (paddr == ADDR_W'(8'h78));

  // R1: reset clears the pin-facing outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (gpio_oe == 32'h0 && gpio_out == 32'h0));

  // R2: bits whose enable is 0 keep their value on a low-data write
  p_masked_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && paddr == ADDR_W'(8'h00)) |=>
      (((gpio_out[15:0] ^ $past(gpio_out[15:0])) & ~$past(pwdata[31:16])) == 16'h0));

  // R6: half-register reads have a zero upper half
  p_read_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && half_addr) |-> (prdata[31:16] == 16'h0));

  // R8: version word is nonzero
  p_version_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && paddr == ADDR_W'(8'h78)) |-> (prdata != 32'h0));

  // R9: unmapped offsets read zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !mapped) |-> (prdata == 32'h0));

  // R10: no write strobe, no output change
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_acc |=> ($stable(gpio_oe) && $stable(gpio_out)));
endmodule

bind gpio_mask_bank gpio_mask_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pwdata   (pwdata),
  .prdata   (prdata),
  .gpio_oe  (gpio_oe),
  .gpio_out (gpio_out)
);

// File: tb/sim_gpio_mask_bank.sv
module sim_gpio_mask_bank;
  localparam int          CLK_PERIOD = 10;
  localparam int          AW         = 8;
  localparam logic [31:0] VER        = 32'h0002_0517;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [31:0]   pwdata, prdata, gpio_in, gpio_oe, gpio_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  gpio_mask_bank #(.ADDR_W(AW), .SYNC_STAGES(2), .VERSION_ID(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .gpio_in(gpio_in), .gpio_oe(gpio_oe), .gpio_out(gpio_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish act=%0d exp<=20000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] r;
    check("R1 oe", gpio_oe, 32'h0);
    check("R1 out", gpio_out, 32'h0);
    for (int a = 0; a < 16; a += 4) begin
      bus_read(8'(a), r);
      check("R1 reg", r, 32'h0);
    end
  endtask

  task automatic t_low_data;
    logic [31:0] r;
    bus_write(8'h00, 32'hFFFF_A5A5);
    check("R2 full mask", gpio_out, 32'h0000_A5A5);
    bus_write(8'h00, 32'h00F0_FFFF);
    check("R2 partial mask", gpio_out, 32'h0000_A5F5);
    bus_write(8'h00, 32'h0000_0000);
    check("R2 empty mask", gpio_out, 32'h0000_A5F5);
    bus_write(8'h00, 32'h0101_0000);
    check("R5 clear pins", gpio_out, 32'h0000_A4F4);
    bus_read(8'h00, r);
    check("R6 read low data", r, 32'h0000_A4F4);
  endtask

  task automatic t_high_data;
    logic [31:0] r;
    bus_write(8'h04, 32'h8001_FFFF);
    check("R3 high pins", gpio_out, 32'h8001_A4F4);
    bus_write(8'h04, 32'h0F00_0300);
    check("R3 high partial", gpio_out, 32'h8301_A4F4);
    bus_read(8'h04, r);
    check("R6 read high data", r, 32'h0000_8301);
  endtask

  task automatic t_direction;
    logic [31:0] r;
    bus_write(8'h08, 32'hFFFF_1234);
    check("R4 dir low", gpio_oe, 32'h0000_1234);
    bus_write(8'h0C, 32'h0F00_0A00);
    check("R4 dir high", gpio_oe, 32'h0A00_1234);
    bus_write(8'h08, 32'h0030_0000);
    check("R4 dir clear", gpio_oe, 32'h0A00_1204);
    check("R5 data untouched by dir", gpio_out, 32'h8301_A4F4);
    bus_read(8'h0C, r);
    check("R6 read dir high", r, 32'h0000_0A00);
  endtask

  task automatic t_levels;
    logic [31:0] r;
    @(negedge clk) gpio_in = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    bus_read(8'h70, r);
    check("R7 level A", r, 32'hDEAD_BEEF);
    @(negedge clk) gpio_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    bus_read(8'h70, r);
    check("R7 level B", r, 32'h1234_5678);
  endtask

  task automatic t_version;
    logic [31:0] r;
    bus_read(8'h78, r);
    check("R8 version", r, VER);
    bus_write(8'h78, 32'hFFFF_FFFF);
    bus_write(8'h70, 32'hFFFF_FFFF);
    bus_read(8'h78, r);
    check("R8 version after write", r, VER);
    check("R8 out after ro write", gpio_out, 32'h8301_A4F4);
    check("R8 oe after ro write", gpio_oe, 32'h0A00_1204);
  endtask

  task automatic t_unmapped;
    logic [31:0] r;
    bus_write(8'h40, 32'hFFFF_FFFF);
    bus_write(8'h10, 32'hFFFF_0000);
    check("R9 out after unmapped write", gpio_out, 32'h8301_A4F4);
    check("R9 oe after unmapped write", gpio_oe, 32'h0A00_1204);
    bus_read(8'h40, r);
    check("R9 read 0x40", r, 32'h0);
    bus_read(8'h10, r);
    check("R9 read 0x10", r, 32'h0);
  endtask

  task automatic t_strobe;
    // setup phase only, then enable without select
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 8'h00; pwdata = 32'hFFFF_0000;
    @(negedge clk);
    psel = 1'b0; penable = 1'b1;
    @(negedge clk);
    psel = 1'b1; penable = 1'b1; pwrite = 1'b0;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    check("R10 out no strobe", gpio_out, 32'h8301_A4F4);
  endtask

  initial begin
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; gpio_in = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", gpio_oe | gpio_out, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_low_data;
    t_high_data;
    t_direction;
    t_levels;
    t_version;
    t_unmapped;
    t_strobe;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule